// File: doc/BRIEF.md
# Dual Up/Down Wiper Position Controller

This block keeps the tap positions of two digitally controlled resistor channels. Each position is held in a 7-bit saturating counter, so it can take 128 values. A push-button style interface steps the counters. The inputs are an external count strobe, an active-low chip select, a direction input, a mode input and a channel select input. The design samples the strobe and the chip select into the system clock domain. Each falling edge of the strobe then produces exactly one step.

In common mode both channels step together, so the spacing between them stays the same. If either channel is already at the end of its range in the requested direction, neither channel moves. In independent mode only the selected channel steps, and it saturates on its own. For each channel the block outputs the current code and a one-hot tap-select vector that drives the switch array of that channel.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: While rst_ni is low, and after its release, both codes read 0x40 and both tap vectors have only bit 64 set.
- R2: A falling edge of strobe_i is synchronized through two flops and detected once. The codes change on the third rising clock edge after the strobe is first sampled low. Each fall gives at most one step, however long strobe_i stays low.
- R3: A strobe fall has no effect while the synchronized cs_ni is high. Both codes stay the same.
- R4: When up_i is 1 a step adds one to the code (toward full scale). When up_i is 0 a step subtracts one (toward zero scale).
- R5: The codes saturate. An upward step at 0x7F and a downward step at 0x00 leave the code unchanged, and the code never wraps.
- R6: When indep_i is 0 (common mode), one step moves both codes by the same amount in the same direction.
- R7: In common mode, if either code is already at 0x7F for an upward step, or at 0x00 for a downward step, neither code moves.
- R8: When indep_i is 1, sel_i = 0 steps only channel 1 and sel_i = 1 steps only channel 2. The other channel's code stays the same.
- R9: Each tap vector is one-hot, with only bit index equal to that channel's code set. It changes in the same cycle as the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Count strobe; its falling edge requests a step |
| cs_ni | input | 1 | Chip select, active low |
| up_i | input | 1 | Direction: 1 = increment, 0 = decrement |
| indep_i | input | 1 | Mode: 0 = common, 1 = independent |
| sel_i | input | 1 | Channel select in independent mode: 0 = channel 1, 1 = channel 2 |
| code1_o | output | 7 | Channel 1 wiper code |
| code2_o | output | 7 | Channel 2 wiper code |
| tap1_o | output | 128 | Channel 1 one-hot tap select |
| tap2_o | output | 128 | Channel 2 one-hot tap select |

## Verification
A common-mode step and end-of-range saturation can fall on the same strobe. One channel sits at a limit while the other is still free to move. The bench sets this up with independent steps: it drives channel 1 to 0x7F and channel 2 to 0x00. It then issues common-mode strobes in both directions. A behavioural reference model predicts that both codes stay frozen, and it is compared with both codes and both tap vectors on every clock. The bench then backs each channel off its limit and shows that common stepping resumes with the spacing kept.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int unsigned CODE_W = 7;
  localparam int unsigned TAPS   = 1 << CODE_W;
  localparam int unsigned NCH    = 2;

  typedef struct packed {
    logic up;
    logic indep;
    logic sel;
  } step_cmd_t;
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned NCH    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_s_i,
  input  logic                       cs_ns_i,
  input  wiper_pkg::step_cmd_t       cmd_i,
  input  logic [NCH-1:0][CODE_W-1:0] code_i,
  output logic [NCH-1:0]             en_o,
  output logic                       up_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic strobe_prev_q;
  logic fall, go;
  logic [NCH-1:0] at_top, at_bot;
  logic blocked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_prev_q <= 1'b0;
    else         strobe_prev_q <= strobe_s_i;
  end

  assign fall = strobe_prev_q & ~strobe_s_i;
  assign go   = fall & ~cs_ns_i;

  for (genvar c = 0; c < NCH; c++) begin : g_lim
    assign at_top[c] = (code_i[c] == CODE_MAX);
    assign at_bot[c] = (code_i[c] == '0);
  end

  // common mode: any channel at the end in the step direction freezes all
  assign blocked = cmd_i.up ? |at_top : |at_bot;

  always_comb begin
    en_o = '0;
    if (go) begin
      if (cmd_i.indep) en_o[cmd_i.sel] = 1'b1;
      else if (!blocked) en_o = '1;
    end
  end

  assign up_o = cmd_i.up;

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> !fall);

  // R3
  cs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ns_i |-> (en_o == '0));

  // R7
  common_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i.indep && (en_o != '0)) |-> (&en_o));

  // R8
  indep_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.indep |-> $onehot0(en_o));
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int unsigned       CODE_W = 7,
  parameter logic [CODE_W-1:0] RST_CODE = 7'h40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= RST_CODE;
    else if (en_i) begin
      if (up_i && code_q != CODE_MAX)    code_q <= code_q + 1'b1;
      else if (!up_i && code_q != '0)    code_q <= code_q - 1'b1;
    end
  end

  assign code_o = code_q;

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(code_q));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && code_q == CODE_MAX) |=> (code_q == CODE_MAX));

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !up_i && code_q == '0) |=> (code_q == '0));

  // R4
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && code_q != CODE_MAX) |=> (code_q == $past(code_q) + 1'b1));
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned TAPS   = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [TAPS-1:0]   tap_o
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_o[t] = (code_i == t[CODE_W-1:0]);
  end

  // R9
  tap_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_o) == 1);

  // R9
  tap_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[code_i]);
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl #(
  parameter int unsigned CODE_W      = wiper_pkg::CODE_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TAPS       = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              cs_ni,
  input  logic              up_i,
  input  logic              indep_i,
  input  logic              sel_i,
  output logic [CODE_W-1:0] code1_o,
  output logic [CODE_W-1:0] code2_o,
  output logic [TAPS-1:0]   tap1_o,
  output logic [TAPS-1:0]   tap2_o
);
  localparam int unsigned       NCH      = wiper_pkg::NCH;
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(1 << (CODE_W - 1));

  logic strobe_s, cs_ns, up;
  logic [NCH-1:0]             en;
  logic [NCH-1:0][CODE_W-1:0] code;
  logic [NCH-1:0][TAPS-1:0]   tap;
  wiper_pkg::step_cmd_t       cmd;

  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(strobe_i), .q_o(strobe_s));

  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_ns));

  assign cmd = '{up: up_i, indep: indep_i, sel: sel_i};

  wiper_step_ctrl #(.CODE_W(CODE_W), .NCH(NCH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_s_i(strobe_s), .cs_ns_i(cs_ns),
    .cmd_i(cmd), .code_i(code), .en_o(en), .up_o(up));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wiper_counter #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en[c]), .up_i(up), .code_o(code[c]));
    wiper_tap_decode #(.CODE_W(CODE_W), .TAPS(TAPS)) u_dec (
      .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code[c]), .tap_o(tap[c]));
  end

  assign code1_o = code[0];
  assign code2_o = code[1];
  assign tap1_o  = tap[0];
  assign tap2_o  = tap[1];

  // R6
  spacing_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(indep_i) && $past(en) != '0) |->
      (code1_o - code2_o) == $past(code1_o - code2_o));
endmodule

// File: tb/tb_dual_wiper_ctrl.sv
`timescale 1ns/1ps
module tb_dual_wiper_ctrl;
  localparam int TAPS = 128;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic strobe_i = 1'b1, cs_ni = 1'b1, up_i = 1'b0, indep_i = 1'b0, sel_i = 1'b0;
  logic [6:0] code1_o, code2_o;
  logic [TAPS-1:0] tap1_o, tap2_o;

  int vectors = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  int m1, m2;
  int hs[$], hc[$];

  always #2.5 clk_i = ~clk_i;

  dual_wiper_ctrl dut (.*);

  // behavioural reference: input history sampled each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1 = 64; m2 = 64;
      hs = '{0, 0, 0}; hc = '{1, 1, 1};
    end else begin
      if (hs[2] == 1 && hs[1] == 0 && hc[1] == 0) begin
        if (indep_i) begin
          if (!sel_i) m1 = up_i ? (m1 < 127 ? m1 + 1 : m1) : (m1 > 0 ? m1 - 1 : m1);
          else        m2 = up_i ? (m2 < 127 ? m2 + 1 : m2) : (m2 > 0 ? m2 - 1 : m2);
        end else if (up_i) begin
          if (m1 < 127 && m2 < 127) begin m1++; m2++; end
        end else begin
          if (m1 > 0 && m2 > 0) begin m1--; m2--; end
        end
      end
      hs.push_front(int'(strobe_i)); void'(hs.pop_back());
      hc.push_front(int'(cs_ni));    void'(hc.pop_back());
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check({phase, " code1"}, int'(code1_o), m1);
      check({phase, " code2"}, int'(code2_o), m2);
      vectors++;
      if (tap1_o != (TAPS'(1) << m1) || tap2_o != (TAPS'(1) << m2)) begin
        fails++;
        $display("FAIL R9: tap1 idx %0d tap2 idx %0d expected %0d %0d",
                 $clog2(tap1_o), $clog2(tap2_o), m1, m2);
      end
    end
  end

  task automatic pulse(bit up, bit ind, bit sel, int low = 2, bit cs = 0);
    @(negedge clk_i);
    up_i = up; indep_i = ind; sel_i = sel; cs_ni = cs;
    repeat (3) @(negedge clk_i);
    strobe_i = 1'b0;
    repeat (low) @(negedge clk_i);
    strobe_i = 1'b1;
    repeat (5) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset code1", int'(code1_o), 64);
    check("R1 reset code2", int'(code2_o), 64);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 after release", int'(code1_o), 64);

    phase = "R2";
    @(negedge clk_i); cs_ni = 0; up_i = 1; indep_i = 0;
    repeat (3) @(negedge clk_i);
    strobe_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    check("R2 no change before third edge", int'(code1_o), 64);
    @(negedge clk_i);
    check("R2 step on third edge", int'(code1_o), 65);
    repeat (10) @(negedge clk_i);
    strobe_i = 1;
    repeat (5) @(negedge clk_i);
    check("R2 one step per long fall", int'(code1_o), 65);

    phase = "R4";
    repeat (4) pulse(1, 0, 0);
    check("R4 up", int'(code2_o), 69);
    repeat (3) pulse(0, 0, 0);
    check("R4 down", int'(code1_o), 66);

    phase = "R3";
    repeat (3) pulse(1, 0, 0, 2, 1);
    check("R3 cs high ignored", int'(code1_o), 66);

    phase = "R8";
    repeat (3) pulse(1, 1, 0);
    repeat (5) pulse(0, 1, 1);
    check("R8 ch1 only", int'(code1_o), 69);
    check("R8 ch2 only", int'(code2_o), 61);

    phase = "R6";
    repeat (2) pulse(1, 0, 0);
    check("R6 spacing", int'(code1_o) - int'(code2_o), 8);

    phase = "R5";
    repeat (62) pulse(1, 1, 0);
    check("R5 top saturate", int'(code1_o), 127);
    repeat (66) pulse(0, 1, 1);
    check("R5 bottom saturate", int'(code2_o), 0);

    phase = "R7";
    repeat (2) pulse(1, 0, 0);
    repeat (2) pulse(0, 0, 0);
    check("R7 blocked ch1", int'(code1_o), 127);
    check("R7 blocked ch2", int'(code2_o), 0);
    repeat (3) pulse(1, 1, 1);
    repeat (2) pulse(1, 0, 0);
    check("R7 blocked by ch1 top", int'(code2_o), 3);
    repeat (2) pulse(0, 0, 0);
    check("R7 common resumes", int'(code1_o), 125);
    check("R6 common resumes ch2", int'(code2_o), 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule